// File: doc/BRIEF.md
# System Reset Sequencer

The sequencer merges four reasons to reset the chip into one active-high reset output. The four reasons are supply start-up, a filtered external pin, a watchdog expiry and a failed clock source.

A pin request or a watchdog request first enters a drain phase. In that phase a bus-monitor enable is raised so the transfer in flight can end. A clock-failure request skips the drain. Every request then holds the reset output until the release conditions hold:
- the pin is released;
- in PLL mode, lock is reported.

After that the output stays high for a fixed count of reference cycles. A one-hot cause vector records which source started the reset.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and nothing at its edge can apply back-pressure. Supply-good low acts as the block's asynchronous power-on reset. The pin, watchdog, lock, clock-failure and stop-capture paths are resynchronised with two-flop chains before the sequencer uses them.

Top module: `rstc_ctrl`

## Requirements
- R1: While `pwr_good` is low, `rst_out` is 1, `bus_mon_en` is 0 and `rst_cause` is 4'b0001. With `pll_mode` at 0, `rst_out` is seen high in exactly 512 cycles after `pwr_good` rises, then goes low.
- R2: With `pll_mode` at 1, `rst_out` stays high while `pll_lock` is 0. Once lock is reported, `rst_out` falls between 512 and 518 cycles later.
- R3: Driving `ext_rst_n` low for 4 or more consecutive rising clock edges produces an external request. A low pulse covering only 3 edges is ignored: no reset and no bus-monitor enable.
- R4: An external or watchdog request raises `bus_mon_en` while `rst_out` stays 0. If `bus_done` is 1, the drain lasts exactly one cycle; after the drain `rst_out` rises.
- R5: While `ext_rst_n` is held low, `rst_out` stays high. The 512-cycle stretch begins only after the pin goes high, so `rst_out` falls 512 to 516 cycles after release.
- R6: A rising edge on `wdt_timeout` produces a watchdog request.
- R7: A clock-failure request (`pll_fail` or `ref_fail`) resets the chip only when `pll_mode` and `loc_rst_en` are both 1. It raises `rst_out` without a drain phase.
- R8: The stretch is exactly 512 cycles. A new request while `rst_out` is high restarts it, so the output stays high at least 512 cycles after the newest request.
- R9: `rst_cause` is one-hot: bit 0 supply start-up, bit 1 pin, bit 2 watchdog, bit 3 clock failure. A new request sets its own bit and clears the other three. The vector holds its value while the chip runs.
- R10: When requests arrive in the same cycle, the cause recorded is clock failure first, then watchdog, then pin.
- R11: If `bus_done` stays 0, the drain ends after 16 cycles and the reset proceeds.
- R12: With `stop_mode` at 1, any low pulse on `ext_rst_n`, however short, is captured and becomes an external reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply-good level; low acts as the asynchronous power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog expiry, asynchronous |
| pll_mode | input | 1 | 1 selects PLL clock mode |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| pll_fail | input | 1 | PLL failure flag |
| ref_fail | input | 1 | Reference clock failure flag |
| loc_rst_en | input | 1 | Enables reset on clock failure |
| stop_mode | input | 1 | Low-power stop status |
| bus_done | input | 1 | The bus transfer in flight has finished |
| rst_out | output | 1 | Chip reset, active high |
| bus_mon_en | output | 1 | Bus-monitor enable during the drain |
| rst_cause | output | 4 | One-hot latched reset cause |

## Verification
The assertions take for granted the following input behaviour:
- `ext_rst_n` is high and, in PLL mode, `pll_lock` is 1 at the moment `rst_out` falls; the release only ever follows those conditions, and the stimulus leaves them steady until the reset has completed.
- `bus_done` is a level that stays constant through each drain.
- Requests are not issued while `pwr_good` is low.

The stimulus changes inputs only on falling clock edges and restores every input to idle before the next scenario. The bench samples outputs a quarter period after each rising edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_WAIT    = 2'd2,
    ST_STRETCH = 2'd3
  } rstc_state_e;

  localparam int CAUSE_W   = 4;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_EXT = 1;
  localparam int CAUSE_WDT = 2;
  localparam int CAUSE_LOC = 3;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= {W{RST_VAL}};
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= {W{RST_VAL}};
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  output logic req
);
  localparam int CW = (MIN_EDGES > 1) ? $clog2(MIN_EDGES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_EDGES - 1);

  logic [CW-1:0] cnt;
  logic          fired;

  // One request per low period, raised on the MIN_EDGES-th low sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!pin_low) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!fired) begin
      if (cnt == LAST) fired <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  assign req = pin_low && !fired && (cnt == LAST);
endmodule

// File: rtl/rstc_stop_catch.sv
module rstc_stop_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_mode,
  input  logic pin_n,
  input  logic clr,
  output logic flag
);
  logic set_a;
  assign set_a = stop_mode & ~pin_n;

  // Set needs no clock edge, so a pin pulse during stop is still caught
  always_ff @(posedge clk or negedge rst_n or posedge set_a) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_a) flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end
endmodule

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int EXT_MIN_EDGES  = 4,
  parameter int STRETCH_CYCLES = 512,
  parameter int DRAIN_LIMIT    = 16
) (
  input  logic               clk,
  input  logic               pwr_good,
  input  logic               ext_rst_n,
  input  logic               wdt_timeout,
  input  logic               pll_mode,
  input  logic               pll_lock,
  input  logic               pll_fail,
  input  logic               ref_fail,
  input  logic               loc_rst_en,
  input  logic               stop_mode,
  input  logic               bus_done,
  output logic               rst_out,
  output logic               bus_mon_en,
  output logic [CAUSE_W-1:0] rst_cause
);
  localparam int SCW = $clog2(STRETCH_CYCLES);
  localparam int DCW = $clog2(DRAIN_LIMIT);
  localparam logic [SCW-1:0] S_LAST = SCW'(STRETCH_CYCLES - 1);
  localparam logic [DCW-1:0] D_LAST = DCW'(DRAIN_LIMIT - 1);

  rstc_state_e        state;
  logic [SCW-1:0]     scnt;
  logic [DCW-1:0]     dcnt;
  logic               ext_n_s, wdt_s, lock_s, loc_s, stopf_s;
  logic               wdt_prev, stopf_prev, stop_flag, filt_req;
  logic               loc_raw, ext_req, wdt_req, loc_req, any_req, release_ok;
  logic [CAUSE_W-1:0] next_cause;

  assign loc_raw = pll_mode & loc_rst_en & (pll_fail | ref_fail);

  rstc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
    .clk(clk), .rst_n(pwr_good), .d(ext_rst_n), .q(ext_n_s)
  );

  rstc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_misc (
    .clk(clk), .rst_n(pwr_good),
    .d({wdt_timeout, pll_lock, loc_raw, stop_flag}),
    .q({wdt_s, lock_s, loc_s, stopf_s})
  );

  rstc_pin_filter #(.MIN_EDGES(EXT_MIN_EDGES)) u_filter (
    .clk(clk), .rst_n(pwr_good), .pin_low(~ext_n_s), .req(filt_req)
  );

  rstc_stop_catch u_stop (
    .clk(clk), .rst_n(pwr_good), .stop_mode(stop_mode), .pin_n(ext_rst_n),
    .clr(rst_out), .flag(stop_flag)
  );

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      wdt_prev   <= 1'b0;
      stopf_prev <= 1'b0;
    end else begin
      wdt_prev   <= wdt_s;
      stopf_prev <= stopf_s;
    end
  end

  assign ext_req    = filt_req | (stopf_s & ~stopf_prev);
  assign wdt_req    = wdt_s & ~wdt_prev;
  assign loc_req    = loc_s;
  assign any_req    = ext_req | wdt_req | loc_req;
  assign release_ok = ext_n_s & (~pll_mode | lock_s);

  // Priority: clock failure, then watchdog, then pin
  always_comb begin
    next_cause = '0;
    if (loc_req)      next_cause[CAUSE_LOC] = 1'b1;
    else if (wdt_req) next_cause[CAUSE_WDT] = 1'b1;
    else              next_cause[CAUSE_EXT] = 1'b1;
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      state     <= ST_WAIT;
      scnt      <= '0;
      dcnt      <= '0;
      rst_cause <= CAUSE_W'(1) << CAUSE_POR;
    end else begin
      if (any_req) rst_cause <= next_cause;
      unique case (state)
        ST_RUN: begin
          if (any_req) begin
            state <= loc_req ? ST_WAIT : ST_DRAIN;
            dcnt  <= '0;
          end
        end
        ST_DRAIN: begin
          if (loc_req)                         state <= ST_WAIT;
          else if (bus_done || dcnt == D_LAST) state <= ST_WAIT;
          else                                 dcnt  <= dcnt + 1'b1;
        end
        ST_WAIT: begin
          if (!any_req && release_ok) begin
            state <= ST_STRETCH;
            scnt  <= '0;
          end
        end
        ST_STRETCH: begin
          if (any_req)              state <= ST_WAIT;
          else if (scnt == S_LAST)  state <= ST_RUN;
          else                      scnt  <= scnt + 1'b1;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  assign rst_out    = (state == ST_WAIT) || (state == ST_STRETCH);
  assign bus_mon_en = (state == ST_DRAIN);
endmodule

// File: rtl/rstc_ctrl_chk.sv
module rstc_ctrl_chk #(
  parameter int STRETCH_CYCLES = 512,
  parameter int DRAIN_LIMIT    = 16
) (
  input logic       clk,
  input logic       pwr_good,
  input logic       ext_rst_n,
  input logic       pll_mode,
  input logic       pll_lock,
  input logic       rst_out,
  input logic       bus_mon_en,
  input logic [3:0] rst_cause
);
  localparam int HW = $clog2(STRETCH_CYCLES + 1);
  localparam int MW = $clog2(DRAIN_LIMIT + 2);

  logic [HW-1:0] hi_cnt;
  logic [MW-1:0] mon_cnt;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      hi_cnt  <= '0;
      mon_cnt <= '0;
    end else begin
      if (!rst_out)                         hi_cnt <= '0;
      else if (hi_cnt != HW'(STRETCH_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
      if (!bus_mon_en)                      mon_cnt <= '0;
      else if (mon_cnt != MW'(DRAIN_LIMIT + 1)) mon_cnt <= mon_cnt + 1'b1;
    end
  end

  assert_drain_quiet_R4: assert property (@(posedge clk) disable iff (!pwr_good)
    bus_mon_en |-> !rst_out);

  assert_drain_bound_R11: assert property (@(posedge clk) disable iff (!pwr_good)
    bus_mon_en |-> (mon_cnt < MW'(DRAIN_LIMIT)));

  assert_stretch_len_R8: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(rst_out) |-> (hi_cnt == HW'(STRETCH_CYCLES)));

  assert_release_cond_R5: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(rst_out) |-> (ext_rst_n && (!pll_mode || pll_lock)));

  assert_cause_onehot_R9: assert property (@(posedge clk) disable iff (!pwr_good)
    $countones(rst_cause) == 1);

  assert_cause_hold_R9: assert property (@(posedge clk) disable iff (!pwr_good)
    (!rst_out && !bus_mon_en) |=> ($stable(rst_cause) || rst_out || bus_mon_en));

  assert_nodrain_loc_R7: assert property (@(posedge clk) disable iff (!pwr_good)
    ($rose(rst_out) && !$past(bus_mon_en)) |-> rst_cause[3]);
endmodule

bind rstc_ctrl rstc_ctrl_chk #(
  .STRETCH_CYCLES(STRETCH_CYCLES),
  .DRAIN_LIMIT(DRAIN_LIMIT)
) u_chk (
  .clk(clk), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n), .pll_mode(pll_mode),
  .pll_lock(pll_lock), .rst_out(rst_out), .bus_mon_en(bus_mon_en),
  .rst_cause(rst_cause)
);

// File: tb/rstc_ctrl_bench.sv
module rstc_ctrl_bench;
  logic clk = 1'b0;
  logic pwr_good = 1'b0, ext_rst_n = 1'b1, wdt_timeout = 1'b0;
  logic pll_mode = 1'b0, pll_lock = 1'b1, pll_fail = 1'b0, ref_fail = 1'b0;
  logic loc_rst_en = 1'b1, stop_mode = 1'b0, bus_done = 1'b1;
  logic rst_out, bus_mon_en;
  logic [3:0] rst_cause;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rstc_ctrl u_rstc_ctrl (
    .clk(clk), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n),
    .wdt_timeout(wdt_timeout), .pll_mode(pll_mode), .pll_lock(pll_lock),
    .pll_fail(pll_fail), .ref_fail(ref_fail), .loc_rst_en(loc_rst_en),
    .stop_mode(stop_mode), .bus_done(bus_done), .rst_out(rst_out),
    .bus_mon_en(bus_mon_en), .rst_cause(rst_cause)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 pin, 1 watchdog, 2 clock failure, 3 watchdog+clock failure
    logic        pll;
    logic        bd;
    logic [3:0]  cause;
    logic [4:0]  mon;
    logic [11:0] lo;
    logic [11:0] hi;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{kind: 2'd0, pll: 1'b0, bd: 1'b1, cause: 4'b0010, mon: 5'd1,  lo: 12'd512, hi: 12'd516},
    '{kind: 2'd0, pll: 1'b1, bd: 1'b0, cause: 4'b0010, mon: 5'd16, lo: 12'd512, hi: 12'd516},
    '{kind: 2'd1, pll: 1'b0, bd: 1'b1, cause: 4'b0100, mon: 5'd1,  lo: 12'd512, hi: 12'd516},
    '{kind: 2'd1, pll: 1'b0, bd: 1'b0, cause: 4'b0100, mon: 5'd16, lo: 12'd512, hi: 12'd516},
    '{kind: 2'd2, pll: 1'b1, bd: 1'b1, cause: 4'b1000, mon: 5'd0,  lo: 12'd512, hi: 12'd530},
    '{kind: 2'd3, pll: 1'b1, bd: 1'b1, cause: 4'b1000, mon: 5'd0,  lo: 12'd512, hi: 12'd530}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse(input int n);
    @(negedge clk);
    ext_rst_n = 1'b0;
    cyc(n);
    ext_rst_n = 1'b1;
  endtask

  task automatic wdt_pulse();
    @(negedge clk);
    wdt_timeout = 1'b1;
    cyc(1);
    wdt_timeout = 1'b0;
  endtask

  // Wait up to 100 cycles for rst_out, counting bus-monitor cycles, then time the pulse
  task automatic observe(output int mon, output int dur, output bit rose);
    mon = 0; dur = 0; rose = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #5;
      if (bus_mon_en) mon++;
      if (rst_out) begin rose = 1'b1; break; end
    end
    if (rose) begin
      dur = 1;
      for (int i = 0; i < 3000; i++) begin
        @(posedge clk); #5;
        if (rst_out) dur++;
        else break;
      end
    end
  endtask

  task automatic stim(input vec_t v);
    @(negedge clk);
    case (v.kind)
      2'd0: pin_pulse(5);
      2'd1: wdt_pulse();
      default: begin
        pll_lock = 1'b0;
        pll_fail = 1'b1;
        if (v.kind == 2'd3) wdt_timeout = 1'b1;
        cyc(1);
        wdt_timeout = 1'b0;
        cyc(4);
        pll_fail = 1'b0;
        pll_lock = 1'b1;
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int mon, dur;
    bit rose;

    // R1: held in reset while supply is not good
    cyc(3);
    chk(rst_out == 1'b1, "R1 rst_out during supply low", rst_out, 1);
    chk(bus_mon_en == 1'b0, "R1 bus_mon_en during supply low", bus_mon_en, 0);
    chk(rst_cause == 4'b0001, "R1 cause during supply low", rst_cause, 1);
    pwr_good = 1'b1;
    dur = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #5;
      if (rst_out) dur++;
      else break;
    end
    chk(dur == 512, "R1 power-on stretch length", dur, 512);

    // Table walk: R3 R4 R6 R7 R9 R10 R11
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      pll_mode = VECS[k].pll;
      bus_done = VECS[k].bd;
      cyc(6);
      chk(rst_out == 1'b0, "R9 idle before vector", rst_out, 0);
      fork
        stim(VECS[k]);
        observe(mon, dur, rose);
      join
      chk(rose, "R4 reset asserted for vector", rose, 1);
      chk(mon == int'(VECS[k].mon), "R11 drain cycles (R4/R7)", mon, VECS[k].mon);
      chk(dur >= int'(VECS[k].lo) && dur <= int'(VECS[k].hi), "R8 stretch duration", dur, VECS[k].lo);
      chk(rst_cause == VECS[k].cause, "R10 cause after vector (R6/R7/R9)", rst_cause, VECS[k].cause);
    end

    // R3: a 3-edge pulse is ignored, a 4-edge pulse is accepted
    @(negedge clk);
    pll_mode = 1'b0; bus_done = 1'b1;
    cyc(4);
    fork
      pin_pulse(3);
      observe(mon, dur, rose);
    join
    chk(!rose && mon == 0, "R3 short pulse ignored", rose, 0);
    chk(rst_cause == 4'b1000, "R3 cause untouched by short pulse", rst_cause, 8);
    fork
      pin_pulse(4);
      observe(mon, dur, rose);
    join
    chk(rose, "R3 four-edge pulse accepted", rose, 1);
    chk(rst_cause == 4'b0010, "R3 cause after four-edge pulse", rst_cause, 2);

    // R5: stretch starts only after the pin is released
    cyc(4);
    @(negedge clk);
    ext_rst_n = 1'b0;
    cyc(40);
    chk(rst_out == 1'b1, "R5 held while pin low", rst_out, 1);
    ext_rst_n = 1'b1;
    dur = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #5;
      if (rst_out) dur++;
      else break;
    end
    chk(dur >= 512 && dur <= 516, "R5 stretch after release", dur, 514);

    // R7: clock failure gated by mode and enable
    cyc(4);
    @(negedge clk);
    pll_mode = 1'b1; loc_rst_en = 1'b0;
    fork
      begin @(negedge clk); pll_fail = 1'b1; cyc(10); pll_fail = 1'b0; end
      observe(mon, dur, rose);
    join
    chk(!rose, "R7 no reset with enable clear", rose, 0);
    @(negedge clk);
    pll_mode = 1'b0; loc_rst_en = 1'b1;
    fork
      begin @(negedge clk); ref_fail = 1'b1; cyc(10); ref_fail = 1'b0; end
      observe(mon, dur, rose);
    join
    chk(!rose, "R7 no reset outside PLL mode", rose, 0);
    chk(rst_cause == 4'b0010, "R7 cause untouched", rst_cause, 2);

    // R8: new request during the stretch restarts it
    fork
      begin wdt_pulse(); cyc(250); pin_pulse(5); end
      observe(mon, dur, rose);
    join
    chk(dur >= 762, "R8 stretch restarted", dur, 762);
    chk(rst_cause == 4'b0010, "R9 newest cause replaces older", rst_cause, 2);

    // R12: brief pin pulse in stop mode
    @(negedge clk);
    stop_mode = 1'b1;
    cyc(2);
    fork
      begin ext_rst_n = 1'b0; cyc(1); ext_rst_n = 1'b1; cyc(3); stop_mode = 1'b0; end
      observe(mon, dur, rose);
    join
    chk(rose, "R12 stop-mode pulse caught", rose, 1);
    chk(rst_cause == 4'b0010, "R12 cause after stop pulse", rst_cause, 2);

    // R2: PLL mode power-up waits for lock; R9 power-on clears other bits
    @(negedge clk);
    pll_mode = 1'b1; pll_lock = 1'b0; pwr_good = 1'b0;
    cyc(2);
    chk(rst_cause == 4'b0001, "R9 power-on clears other causes", rst_cause, 1);
    pwr_good = 1'b1;
    fork
      begin cyc(600); pll_lock = 1'b1; end
      begin
        dur = 0;
        for (int i = 0; i < 3000; i++) begin
          @(posedge clk); #5;
          if (rst_out) dur++;
          else break;
        end
      end
    join
    chk(dur >= 1112 && dur <= 1118, "R2 release after lock", dur, 1114);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule